// File: doc/BRIEF.md
# MSI Doorbell Capture and Interrupt Controller

This block receives message-signalled interrupts on the root-complex side of a PCIe link. Software programs a 64-bit doorbell address, an enable vector and a mask vector through a 32-bit register port. An endpoint raises an interrupt by writing a vector number to the doorbell address. If that vector is enabled, the matching bit of a 32-bit pending vector is set, and the block raises a single level interrupt toward the CPU.

The interrupt line is a held state. A doorbell capture that leaves an unmasked pending bit raises it. Software acknowledges vectors by writing a toggle pattern into the pending register. The line drops only when such a write leaves the whole pending vector empty. A mask write on its own never moves the line. Register reads return data one cycle after the request, with a one-cycle valid strobe.

Top module: `msi_capture_irq`

## Requirements
- R1: After reset the doorbell address, enable, mask and pending registers read as zero, `irq` is low and `reg_rvalid` is low.
- R2: The doorbell address is two 32-bit halves, low at offset 0x820 and high at 0x824. Writing one half leaves the other half unchanged.
- R3: Enable sits at 0x828, mask at 0x82C and pending at 0x830, and each reads back its current value. Read data and `reg_rvalid`=1 appear in the cycle after a read request.
- R4: An accepted doorbell write carrying value V (0 to 31) with enable bit V set sets pending bit V in the next cycle.
- R5: A doorbell write whose value selects an enable bit that is 0 changes neither pending nor `irq`. While the whole enable vector is zero, no doorbell write is accepted. The window reopens as soon as enable becomes nonzero again, without the address being rewritten.
- R6: A doorbell write whose value is 32 or more changes neither pending nor `irq`.
- R7: A doorbell write is accepted only if its address equals the programmed 64-bit address, its two low address bits are zero and all four byte enables are set. Any other inbound write is ignored.
- R8: A register write to the pending register XORs the written data into pending. This can also set bits, and that does not raise `irq`.
- R9: `irq` rises in the cycle after an accepted capture when the resulting pending vector has a bit whose mask bit is 0. A capture of a masked vector leaves `irq` as it was.
- R10: `irq` falls only in the cycle after a pending-register write that leaves pending all zero. Mask writes and partial acknowledges leave it high.
- R11: When a capture and a pending-register write happen in the same cycle, the XOR is applied first and the captured bit is ORed in afterwards, so the new event survives.
- R12: A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register request strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data strobe, one cycle after a read |
| inb_valid | input | 1 | Inbound memory write strobe |
| inb_addr | input | 64 | Inbound write address |
| inb_be | input | 4 | Inbound write byte enables |
| inb_data | input | 32 | Inbound write data (vector number) |
| irq | output | 1 | Level interrupt toward the CPU |

## Verification
A doorbell capture and a software acknowledge of the pending register can land on the same clock edge. The bench provokes this with a single cycle that drives a pending-register write and an inbound doorbell write together. It covers both a different vector and the very vector being acknowledged. It then reads pending back and compares it, and the `irq` level, against a model that applies the XOR first and the capture bit second.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    parameter int unsigned REG_AW = 12;

    localparam logic [REG_AW-1:0] OFF_BASE_LO = 12'h820;
    localparam logic [REG_AW-1:0] OFF_BASE_HI = 12'h824;
    localparam logic [REG_AW-1:0] OFF_ENABLE  = 12'h828;
    localparam logic [REG_AW-1:0] OFF_MASK    = 12'h82C;
    localparam logic [REG_AW-1:0] OFF_PENDING = 12'h830;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BASE_LO,
        SEL_BASE_HI,
        SEL_ENABLE,
        SEL_MASK,
        SEL_PENDING
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [REG_AW-1:0] off);
        reg_sel_e sel;
        case (off)
            OFF_BASE_LO: sel = SEL_BASE_LO;
            OFF_BASE_HI: sel = SEL_BASE_HI;
            OFF_ENABLE:  sel = SEL_ENABLE;
            OFF_MASK:    sel = SEL_MASK;
            OFF_PENDING: sel = SEL_PENDING;
            default:     sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/msi_cap_regfile.sv
module msi_cap_regfile
    import msi_cap_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BASE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] pending_i,
    output logic [BASE_W-1:0] base_o,
    output logic [DATA_W-1:0] enable_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              pend_wr_o,
    output logic [DATA_W-1:0] pend_wval_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [DATA_W-1:0] en;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     wr_req, rd_req;

    always_comb begin
        sel    = decode_offset(reg_addr);
        wr_req = reg_valid && reg_write;
        rd_req = reg_valid && !reg_write;
        regs_d = regs_q;
        regs_d.rvalid = 1'b0;
        if (wr_req) begin
            case (sel)
                SEL_BASE_LO: regs_d.base[DATA_W-1:0]      = reg_wdata;
                SEL_BASE_HI: regs_d.base[BASE_W-1:DATA_W] = reg_wdata;
                SEL_ENABLE:  regs_d.en   = reg_wdata;
                SEL_MASK:    regs_d.mask = reg_wdata;
                default: ;
            endcase
        end
        if (rd_req) begin
            regs_d.rvalid = 1'b1;
            case (sel)
                SEL_BASE_LO: regs_d.rdata = regs_q.base[DATA_W-1:0];
                SEL_BASE_HI: regs_d.rdata = regs_q.base[BASE_W-1:DATA_W];
                SEL_ENABLE:  regs_d.rdata = regs_q.en;
                SEL_MASK:    regs_d.rdata = regs_q.mask;
                SEL_PENDING: regs_d.rdata = pending_i;
                default:     regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign base_o      = regs_q.base;
    assign enable_o    = regs_q.en;
    assign mask_o      = regs_q.mask;
    assign rdata_o     = regs_q.rdata;
    assign rvalid_o    = regs_q.rvalid;
    assign pend_wr_o   = wr_req && (sel == SEL_PENDING);
    assign pend_wval_o = reg_wdata;

    p_base_hi_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == SEL_BASE_LO) |=> $stable(regs_q.base[BASE_W-1:DATA_W]));
    p_base_lo_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == SEL_BASE_HI) |=> $stable(regs_q.base[DATA_W-1:0]));
    p_read_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == SEL_PENDING) |=> (rvalid_o && rdata_o == $past(pending_i)));
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == SEL_NONE) |=> (rdata_o == '0));

endmodule

// File: rtl/msi_cap_window.sv
module msi_cap_window #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BASE_W  = 2 * DATA_W,
    localparam int unsigned BE_W    = DATA_W / 8,
    localparam int unsigned ALIGN_W = $clog2(BE_W),
    localparam int unsigned IDX_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inb_valid,
    input  logic [BASE_W-1:0] inb_addr,
    input  logic [BE_W-1:0]   inb_be,
    input  logic [DATA_W-1:0] inb_data,
    input  logic [BASE_W-1:0] base_i,
    input  logic [DATA_W-1:0] enable_i,
    output logic              evt_o,
    output logic [DATA_W-1:0] onehot_o
);

    logic window_open;
    logic addr_hit;
    logic in_range;

    assign window_open = |enable_i;
    assign addr_hit    = inb_valid && window_open && (&inb_be)
                         && (inb_addr[ALIGN_W-1:0] == '0)
                         && (inb_addr == base_i);
    assign in_range    = (inb_data[DATA_W-1:IDX_W] == '0);

    for (genvar v = 0; v < DATA_W; v++) begin : g_vec
        assign onehot_o[v] = addr_hit && in_range && enable_i[v]
                             && (inb_data[IDX_W-1:0] == IDX_W'(v));
    end

    assign evt_o = |onehot_o;

    p_single_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ($countones(onehot_o) == 1));
    p_closed_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i == '0) |-> !evt_o);
    p_aligned_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (inb_addr == base_i && inb_be == '1));
    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inb_data >= DATA_W) |-> !evt_o);

endmodule

// File: rtl/msi_cap_status.sv
module msi_cap_status #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic [DATA_W-1:0] onehot_i,
    input  logic              pend_wr_i,
    input  logic [DATA_W-1:0] pend_wval_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] pending_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic              irq;
    } st_t;

    st_t               st_d, st_q;
    logic [DATA_W-1:0] merged;

    always_comb begin
        st_d   = st_q;
        merged = st_q.pend;
        if (pend_wr_i) merged = merged ^ pend_wval_i;
        if (evt_i)     merged = merged | onehot_i;
        st_d.pend = merged;
        if (evt_i && |(merged & ~mask_i))      st_d.irq = 1'b1;
        else if (pend_wr_i && merged == '0)    st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_o = st_q.pend;
    assign irq_o     = st_q.irq;

    p_capture_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> ((st_q.pend & $past(onehot_i)) == $past(onehot_i)));
    p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i && !pend_wr_i) |=> ($stable(st_q.pend) && $stable(st_q.irq)));
    p_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(evt_i));
    p_fall_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.irq) |-> ($past(pend_wr_i) && st_q.pend == '0));
    p_irq_has_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.pend != '0));

endmodule

// File: rtl/msi_capture_irq.sv
module msi_capture_irq
    import msi_cap_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BASE_W = 2 * DATA_W,
    localparam int unsigned BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic              inb_valid,
    input  logic [BASE_W-1:0] inb_addr,
    input  logic [BE_W-1:0]   inb_be,
    input  logic [DATA_W-1:0] inb_data,
    output logic              irq
);

    logic [BASE_W-1:0] base_w;
    logic [DATA_W-1:0] enable_w, mask_w, pend_wval_w, pending_w, onehot_w;
    logic              pend_wr_w, evt_w;

    msi_cap_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .pending_i  (pending_w),
        .base_o     (base_w),
        .enable_o   (enable_w),
        .mask_o     (mask_w),
        .pend_wr_o  (pend_wr_w),
        .pend_wval_o(pend_wval_w),
        .rdata_o    (reg_rdata),
        .rvalid_o   (reg_rvalid)
    );

    msi_cap_window #(.DATA_W(DATA_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .inb_valid(inb_valid),
        .inb_addr (inb_addr),
        .inb_be   (inb_be),
        .inb_data (inb_data),
        .base_i   (base_w),
        .enable_i (enable_w),
        .evt_o    (evt_w),
        .onehot_o (onehot_w)
    );

    msi_cap_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_w),
        .onehot_i   (onehot_w),
        .pend_wr_i  (pend_wr_w),
        .pend_wval_i(pend_wval_w),
        .mask_i     (mask_w),
        .pending_o  (pending_w),
        .irq_o      (irq)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !reg_rvalid));

endmodule

// File: tb/msi_capture_irq_bench.sv
module msi_capture_irq_bench;

    localparam logic [11:0] A_LO = 12'h820, A_HI = 12'h824, A_EN = 12'h828,
                            A_MK = 12'h82C, A_PD = 12'h830;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        inb_valid = 1'b0;
    logic [63:0] inb_addr = '0;
    logic [3:0]  inb_be = '0;
    logic [31:0] inb_data = '0;
    logic        irq;

    int n_chk = 0, n_bad = 0;

    logic [63:0] m_base = '0;
    logic [31:0] m_en = '0, m_mask = '0, m_pend = '0;
    logic        m_irq = 1'b0;

    always #10 clk = ~clk;

    msi_capture_irq u_msi_capture_irq (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .inb_valid(inb_valid), .inb_addr(inb_addr), .inb_be(inb_be),
        .inb_data(inb_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model(input bit do_pw, input logic [31:0] pw, input bit do_cap,
                         input logic [63:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] p;
        bit evt;
        p = m_pend;
        if (do_pw) p = p ^ pw;
        evt = do_cap && a == m_base && be == 4'hF && a[1:0] == 2'b00
              && m_en != 0 && d < 32 && m_en[d[4:0]];
        if (evt) p = p | (32'h1 << d[4:0]);
        if (evt && (p & ~m_mask) != 0) m_irq = 1'b1;
        else if (do_pw && p == 0)      m_irq = 1'b0;
        m_pend = p;
    endtask

    task automatic drive(input bit rv, input bit rw, input logic [11:0] ra,
                         input logic [31:0] wd, input bit iv, input logic [63:0] ia,
                         input logic [3:0] ibe, input logic [31:0] id);
        reg_valid = rv; reg_write = rw; reg_addr = ra; reg_wdata = wd;
        inb_valid = iv; inb_addr = ia; inb_be = ibe; inb_data = id;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; inb_valid = 1'b0;
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        case (a)
            A_LO: m_base[31:0]  = d;
            A_HI: m_base[63:32] = d;
            A_EN: m_en = d;
            A_MK: m_mask = d;
            A_PD: model(1'b1, d, 1'b0, '0, '0, '0);
            default: ;
        endcase
        drive(1'b1, 1'b1, a, d, 1'b0, '0, '0, '0);
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
        drive(1'b1, 1'b0, a, '0, 1'b0, '0, '0, '0);
        chk("R3 read strobe", {63'b0, reg_rvalid}, 64'd1);
        d = reg_rdata;
    endtask

    task automatic doorbell(input logic [63:0] a, input logic [3:0] be, input logic [31:0] d);
        model(1'b0, '0, 1'b1, a, be, d);
        drive(1'b0, 1'b0, '0, '0, 1'b1, a, be, d);
    endtask

    task automatic both(input logic [31:0] pw, input logic [31:0] d);
        model(1'b1, pw, 1'b1, m_base, 4'hF, d);
        drive(1'b1, 1'b1, A_PD, pw, 1'b1, m_base, 4'hF, d);
    endtask

    task automatic check_state(input string req);
        logic [31:0] v;
        chk({req, " irq"}, {63'b0, irq}, {63'b0, m_irq});
        reg_rd(A_PD, v);
        chk({req, " pending"}, {32'b0, v}, {32'b0, m_pend});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {63'b0, irq}, 64'd0);
        chk("R1 rvalid", {63'b0, reg_rvalid}, 64'd0);
        foreach (m_en[i]) begin end
        reg_rd(A_LO, v); chk("R1 base lo", {32'b0, v}, 64'd0);
        reg_rd(A_HI, v); chk("R1 base hi", {32'b0, v}, 64'd0);
        reg_rd(A_EN, v); chk("R1 enable", {32'b0, v}, 64'd0);
        reg_rd(A_MK, v); chk("R1 mask", {32'b0, v}, 64'd0);
        reg_rd(A_PD, v); chk("R1 pending", {32'b0, v}, 64'd0);

        // R2 halves independent
        reg_wr(A_HI, 32'h0000_00AB);
        reg_wr(A_LO, 32'hFEE0_1000);
        reg_rd(A_HI, v); chk("R2 hi kept", {32'b0, v}, 64'h0000_00AB);
        reg_wr(A_LO, 32'hFEE0_2000);
        reg_rd(A_HI, v); chk("R2 hi kept again", {32'b0, v}, 64'h0000_00AB);
        reg_wr(A_HI, 32'h0000_00CD);
        reg_rd(A_LO, v); chk("R2 lo kept", {32'b0, v}, 64'hFEE0_2000);
        reg_rd(A_HI, v); chk("R2 hi new", {32'b0, v}, 64'h0000_00CD);

        // R12 unmapped offsets
        reg_rd(12'h900, v); chk("R12 unmapped", {32'b0, v}, 64'd0);
        reg_rd(12'h834, v); chk("R12 unmapped", {32'b0, v}, 64'd0);

        // R3 enable / mask readback
        reg_wr(A_EN, 32'h5555_5555);
        reg_rd(A_EN, v); chk("R3 enable", {32'b0, v}, 64'h5555_5555);
        reg_wr(A_MK, 32'h0);
        reg_rd(A_MK, v); chk("R3 mask", {32'b0, v}, 64'h0);

        // R4 R5 R6 sweep of every vector value with alternating enables
        for (int k = 0; k < 36; k++) begin
            doorbell(m_base, 4'hF, k);
            check_state(k < 32 ? (k % 2 == 0 ? "R4 sweep" : "R5 disabled bit") : "R6 out of range");
        end
        // R8 R10 full acknowledge
        reg_wr(A_PD, m_pend);
        check_state("R10 full clear");

        // R9 masked vectors do not raise
        reg_wr(A_EN, 32'hFFFF_FFFF);
        reg_wr(A_MK, 32'hFFFF_0000);
        for (int k = 0; k < 32; k++) begin
            doorbell(m_base, 4'hF, k);
            check_state(k >= 16 ? "R9 masked" : "R9 unmasked");
            reg_wr(A_PD, 32'h1 << k);
            check_state("R10 ack");
        end

        // R10 partial acknowledge and mask write keep irq
        reg_wr(A_MK, 32'h0);
        doorbell(m_base, 4'hF, 3);
        doorbell(m_base, 4'hF, 7);
        reg_wr(A_PD, 32'h8);
        check_state("R10 partial");
        reg_wr(A_MK, 32'hFFFF_FFFF);
        check_state("R10 mask write");
        reg_wr(A_PD, 32'h80);
        check_state("R10 last clear");
        reg_wr(A_MK, 32'h0);

        // R8 XOR can set bits without raising irq
        reg_wr(A_PD, 32'h0000_000F);
        check_state("R8 xor set");
        reg_wr(A_PD, 32'h0000_0005);
        check_state("R8 xor toggle");
        reg_wr(A_PD, 32'h0000_000A);
        check_state("R8 xor clear");

        // R7 non-matching inbound writes
        doorbell(m_base + 64'd4, 4'hF, 1);
        check_state("R7 next word");
        doorbell(m_base + 64'd1, 4'hF, 1);
        check_state("R7 unaligned");
        doorbell(m_base, 4'h7, 1);
        check_state("R7 partial bytes");
        doorbell(m_base ^ 64'h1_0000_0000, 4'hF, 1);
        check_state("R7 high half");

        // R5 window closed while enable is zero, reopens later
        reg_wr(A_EN, 32'h0);
        doorbell(m_base, 4'hF, 5);
        check_state("R5 closed");
        reg_wr(A_EN, 32'h0000_0020);
        doorbell(m_base, 4'hF, 5);
        check_state("R5 reopened");

        // R11 same-cycle capture and acknowledge
        reg_wr(A_EN, 32'hFFFF_FFFF);
        both(32'h0000_0020, 9);
        check_state("R11 other vector");
        both(32'h0000_0200, 9);
        check_state("R11 same vector");
        reg_wr(A_PD, m_pend);
        check_state("R11 cleanup");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule